// File: doc/BRIEF.md
# Dual-Port Parallel Handshake Controller

This block keeps the Ready/Strobe handshake state for a parallel peripheral with two byte-wide ports, called A and B. Each port can be set to one of four modes: byte output, byte input, bidirectional (port A only), or bit-control. The CPU side supplies one-cycle write and read pulses, a port select and write data. The peripheral side supplies an active-low strobe per port and the pin levels. The block drives a Ready line per port, the output data registers, the port A input and port B input registers, and an output enable for the port A pins. It also raises one-clock interrupt request pulses for an external priority arbiter. The arbiter, the control-word decoder and the bit-match interrupt logic are outside this block.

Ready registers update only on the falling clock edge. Handshake events are decided on the rising edge and committed half a cycle later. The strobe inputs are asynchronous, so each one passes through a synchronizer chain of configurable length before its rising edge is detected. In bidirectional mode, port A's strobe gates the port A pin drivers and acknowledges output data. Port B's strobe and Ready carry the input direction of the same port A pins.

Top module: `hsk_dual_port`

## Requirements
- R1: While reset is active and after it is released, both Ready outputs, both interrupt pulses and all data registers are 0.
- R2: In output mode (mode code 2'b00), a write pulse to a port loads its output register at the sampling rising edge. The same write raises that port's Ready at the falling edge that follows.
- R3: In output mode, a strobe rise (strobe_n going from 0 to 1) is acted on at the rising edge SYNC_STAGES+1 cycles after it occurs. That port's Ready then drops at the next falling edge.
- R4: In input mode (2'b01), the port's input register follows the pins while the synchronized strobe is low. It keeps the value captured at the strobe rise. That rise clears Ready with the same timing as R3.
- R5: In input mode, a read pulse to the port sets its Ready at the falling edge after the pulse is sampled.
- R6: In bidirectional mode (port A code 2'b10), oe_a is high only while stb_a_n is low. A write to A raises rdy_a, and a stb_a_n rise clears rdy_a and produces irq_a.
- R7: In bidirectional mode, a stb_b_n rise captures pin_a_in into in_a, clears rdy_b and produces irq_b. A read of port A sets rdy_b.
- R8: In bit-control mode (2'b11), Ready is held low and strobes have no effect on interrupts or input registers. Port B given code 2'b10 behaves as bit-control.
- R9: Each interrupt request is a single-cycle pulse that fires only when that port's enable is high. A disabled port still updates its Ready.
- R10: When a write and a strobe rise are acted on in the same cycle in output mode, Ready ends high. When a read and a strobe rise coincide in input mode, Ready ends low.
- R11: oe_a is high in output mode and low in input and bit-control modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; events on rising edge, Ready on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a | input | 2 | Port A mode: 00 out, 01 in, 10 bidir, 11 bit-control |
| mode_b | input | 2 | Port B mode (10 treated as bit-control) |
| cpu_wr | input | 1 | One-cycle CPU data write pulse |
| cpu_rd | input | 1 | One-cycle CPU data read completion pulse |
| cpu_sel_b | input | 1 | Port select, 1 = port B |
| cpu_wdata | input | DATA_W | Write data |
| irq_en_a | input | 1 | Port A interrupt enable |
| irq_en_b | input | 1 | Port B interrupt enable |
| stb_a_n | input | 1 | Port A strobe, active low, asynchronous |
| stb_b_n | input | 1 | Port B strobe, active low, asynchronous |
| pin_a_in | input | DATA_W | Port A pin levels |
| pin_b_in | input | DATA_W | Port B pin levels |
| rdy_a | output | 1 | Port A Ready |
| rdy_b | output | 1 | Port B Ready |
| out_a | output | DATA_W | Port A output register |
| out_b | output | DATA_W | Port B output register |
| oe_a | output | 1 | Port A pin driver enable |
| in_a | output | DATA_W | Port A input register |
| in_b | output | DATA_W | Port B input register |
| irq_a | output | 1 | Port A interrupt request pulse |
| irq_b | output | 1 | Port B interrupt request pulse |

## Verification
The bench uses DATA_W=8, SYNC_STAGES=2 and the raw-strobe output-enable variant. With these values the latency from a strobe rise to the interrupt pulse is three rising edges. That makes every checked cycle predictable in the bench. It also lets a write or read be placed exactly in the detection cycle to test the collision rules. Both ports are swept through output and input modes with several data patterns and with the interrupt enable both on and off. Bidirectional and bit-control modes are then exercised, including the invalid bidirectional code on port B.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [1:0] {
      HM_OUT    = 2'd0,
      HM_IN     = 2'd1,
      HM_BIDIR  = 2'd2,
      HM_BITCTL = 2'd3
   } hsk_mode_e;

   // Per-port handshake control decided on the rising edge
   typedef struct packed {
      logic set;        // request Ready high
      logic clr;        // request Ready low
      logic set_wins;   // collision rule: set beats clear
      logic force_low;  // mode holds Ready low
      logic irq_evt;    // interrupt-worthy event this cycle
   } hsk_ctl_t;

   localparam int HSK_PORTS = 2;

endpackage

// File: rtl/hsk_strobe_sync.sv
module hsk_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n,
   output logic stb_active,
   output logic stb_rise
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsk_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;
   logic          prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[LAST-1:0], stb_n};
         prev  <= chain[LAST];
      end
   end

   assign stb_active = ~chain[LAST];
   assign stb_rise   = chain[LAST] & ~prev;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |=> !stb_rise);  // R3

endmodule

// File: rtl/hsk_ready_cell.sv
module hsk_ready_cell
   import hsk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  hsk_ctl_t ctl,
   output logic     rdy
);

   logic set_q;
   logic clr_q;
   logic wins_q;

   // Rising edge: capture the decision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q  <= 1'b0;
         clr_q  <= 1'b0;
         wins_q <= 1'b0;
      end else begin
         set_q  <= ctl.set;
         clr_q  <= ctl.clr;
         wins_q <= ctl.set_wins;
      end
   end

   // Falling edge: commit Ready
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy <= 1'b0;
      end else if (ctl.force_low) begin
         rdy <= 1'b0;
      end else if (set_q && (wins_q || !clr_q)) begin
         rdy <= 1'b1;
      end else if (clr_q) begin
         rdy <= 1'b0;
      end
   end

   AST_RDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && !(set_q && wins_q)) |-> !rdy);  // R3

   AST_RDY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (set_q && (wins_q || !clr_q) && !ctl.force_low) |-> rdy);  // R2

endmodule

// File: rtl/hsk_in_latch.sv
module hsk_in_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (open) q <= din;
   end

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(q));  // R4

endmodule

// File: rtl/hsk_dual_port.sv
module hsk_dual_port
   import hsk_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit OE_FROM_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_a,
   input  logic [1:0]        mode_b,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic              cpu_sel_b,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              irq_en_a,
   input  logic              irq_en_b,
   input  logic              stb_a_n,
   input  logic              stb_b_n,
   input  logic [DATA_W-1:0] pin_a_in,
   input  logic [DATA_W-1:0] pin_b_in,
   output logic              rdy_a,
   output logic              rdy_b,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b,
   output logic              oe_a,
   output logic [DATA_W-1:0] in_a,
   output logic [DATA_W-1:0] in_b,
   output logic              irq_a,
   output logic              irq_b
);

   localparam int NP = HSK_PORTS;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hsk_dual_port: DATA_W must be positive");
      end
   endgenerate

   hsk_mode_e ma;
   hsk_mode_e mb;
   assign ma = hsk_mode_e'(mode_a);
   assign mb = hsk_mode_e'(mode_b);

   logic bidir;
   assign bidir = (ma == HM_BIDIR);

   logic wr_a, wr_b, rd_a, rd_b;
   assign wr_a = cpu_wr & ~cpu_sel_b;
   assign wr_b = cpu_wr &  cpu_sel_b;
   assign rd_a = cpu_rd & ~cpu_sel_b;
   assign rd_b = cpu_rd &  cpu_sel_b;

   // Strobe synchronizers
   logic [NP-1:0] stb_n_vec;
   logic [NP-1:0] stb_act;
   logic [NP-1:0] stb_rise;
   assign stb_n_vec = {stb_b_n, stb_a_n};

   genvar gi;
   generate
      for (gi = 0; gi < NP; gi++) begin : g_sync
         hsk_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb_n     (stb_n_vec[gi]),
            .stb_active(stb_act[gi]),
            .stb_rise  (stb_rise[gi])
         );
      end
   endgenerate

   function automatic hsk_ctl_t byte_ctl(hsk_mode_e m, logic wr, logic rd, logic rise);
      hsk_ctl_t c;
      c = '0;
      case (m)
         HM_OUT: begin
            c.set = wr;  c.clr = rise;  c.set_wins = 1'b1;  c.irq_evt = rise;
         end
         HM_IN: begin
            c.set = rd;  c.clr = rise;  c.set_wins = 1'b0;  c.irq_evt = rise;
         end
         default: c.force_low = 1'b1;
      endcase
      return c;
   endfunction

   hsk_ctl_t ctl [NP];
   logic     b_forced;

   always_comb begin
      ctl[0] = byte_ctl(bidir ? HM_OUT : ma, wr_a, rd_a, stb_rise[0]);
      if (bidir)
         ctl[1] = byte_ctl(HM_IN, 1'b0, rd_a, stb_rise[1]);
      else
         ctl[1] = byte_ctl((mb == HM_BIDIR) ? HM_BITCTL : mb, wr_b, rd_b, stb_rise[1]);
   end

   assign b_forced = !bidir && (mb == HM_BITCTL || mb == HM_BIDIR);

   // Ready cells
   logic [NP-1:0] rdy_vec;
   generate
      for (gi = 0; gi < NP; gi++) begin : g_rdy
         hsk_ready_cell i_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .ctl  (ctl[gi]),
            .rdy  (rdy_vec[gi])
         );
      end
   endgenerate
   assign rdy_a = rdy_vec[0];
   assign rdy_b = rdy_vec[1];

   // Output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_a <= '0;
         out_b <= '0;
      end else begin
         if (wr_a) out_a <= cpu_wdata;
         if (wr_b) out_b <= cpu_wdata;
      end
   end

   // Input registers
   logic open_a, open_b;
   assign open_a = ((ma == HM_IN) & stb_act[0]) | (bidir & stb_act[1]);
   assign open_b = ~bidir & (mb == HM_IN) & stb_act[1];

   hsk_in_latch #(.W(DATA_W)) i_lat_a (
      .clk(clk), .rst_n(rst_n), .open(open_a), .din(pin_a_in), .q(in_a));
   hsk_in_latch #(.W(DATA_W)) i_lat_b (
      .clk(clk), .rst_n(rst_n), .open(open_b), .din(pin_b_in), .q(in_b));

   // Interrupt pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= ctl[0].irq_evt & irq_en_a;
         irq_b <= ctl[1].irq_evt & irq_en_b;
      end
   end

   // Port A driver enable
   generate
      if (OE_FROM_SYNC) begin : g_oe_sync
         assign oe_a = (ma == HM_OUT) | (bidir & stb_act[0]);
      end else begin : g_oe_raw
         assign oe_a = (ma == HM_OUT) | (bidir & ~stb_a_n);
         AST_OE_BIDIR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (bidir && stb_a_n) |-> !oe_a);  // R6
      end
   endgenerate

   AST_OE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ma == HM_IN || ma == HM_BITCTL) |-> !oe_a);  // R11

   AST_BITCTL_RDY_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ma == HM_BITCTL && $past(ma == HM_BITCTL)) |-> !rdy_a);  // R8

   AST_BITCTL_RDY_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_forced && $past(b_forced)) |-> !rdy_b);  // R8

   AST_BITCTL_NO_IRQ_B: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_forced) |-> !irq_b);  // R8

   AST_IRQ_A_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |=> !irq_a);  // R9

   AST_IRQ_B_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |=> !irq_b);  // R9

   AST_IRQ_A_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> $past(irq_en_a));  // R9

   AST_IRQ_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> $past(irq_en_b));  // R9

endmodule

// File: tb/test_hsk_dual_port.sv
module test_hsk_dual_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_a = 2'd3, mode_b = 2'd3;
   logic         cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel_b = 1'b0;
   logic [W-1:0] cpu_wdata = '0;
   logic         irq_en_a = 1'b0, irq_en_b = 1'b0;
   logic         stb_a_n = 1'b1, stb_b_n = 1'b1;
   logic [W-1:0] pin_a_in = '0, pin_b_in = '0;
   logic         rdy_a, rdy_b, oe_a, irq_a, irq_b;
   logic [W-1:0] out_a, out_b, in_a, in_b;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   hsk_dual_port #(.DATA_W(W), .SYNC_STAGES(2)) i_hsk_dual_port (
      .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel_b(cpu_sel_b), .cpu_wdata(cpu_wdata),
      .irq_en_a(irq_en_a), .irq_en_b(irq_en_b), .stb_a_n(stb_a_n), .stb_b_n(stb_b_n),
      .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .rdy_a(rdy_a), .rdy_b(rdy_b),
      .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .in_a(in_a), .in_b(in_b),
      .irq_a(irq_a), .irq_b(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic at_fall();
      @(negedge clk); #1;
   endtask

   function automatic logic rdy_of(int p);
      return (p != 0) ? rdy_b : rdy_a;
   endfunction
   function automatic logic irq_of(int p);
      return (p != 0) ? irq_b : irq_a;
   endfunction
   function automatic logic [W-1:0] in_of(int p);
      return (p != 0) ? in_b : in_a;
   endfunction
   function automatic logic [W-1:0] out_of(int p);
      return (p != 0) ? out_b : out_a;
   endfunction

   task automatic set_stb(int p, logic v);
      if (p != 0) stb_b_n = v; else stb_a_n = v;
   endtask

   task automatic cpu_write(int p, logic [W-1:0] d);
      cpu_sel_b = (p != 0); cpu_wdata = d; cpu_wr = 1'b1;
      tick();
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(int p);
      cpu_sel_b = (p != 0); cpu_rd = 1'b1;
      tick();
      cpu_rd = 1'b0;
   endtask

   // Strobe low for 4 cycles, then high; returns two edges after the rise
   task automatic stb_to_detect(int p);
      set_stb(p, 1'b0);
      repeat (4) tick();
      set_stb(p, 1'b1);
      tick();
      tick();
   endtask

   initial begin
      #(200000 * 5);
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) tick();
      chk("R1 rdy_a", rdy_a, 0); chk("R1 rdy_b", rdy_b, 0);
      chk("R1 irq", {irq_a, irq_b}, 0);
      chk("R1 regs", {out_a, out_b, in_a, in_b}, 0);
      rst_n = 1'b1;
      repeat (2) tick();
      chk("R1 rdy after release", {rdy_a, rdy_b}, 0);
      chk("R11 oe bitctl", oe_a, 0);

      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < 4; k++) begin
            logic [W-1:0] d;
            logic en;
            d  = W'((k * 37 + p * 101 + 5) & 255);
            en = k[0];
            irq_en_a = en; irq_en_b = en;
            // Output mode
            if (p != 0) begin mode_b = 2'd0; mode_a = 2'd3; end
            else        begin mode_a = 2'd0; mode_b = 2'd3; end
            tick();
            if (p == 0) chk("R11 oe output mode", oe_a, 1);
            cpu_write(p, d);
            chk("R2 out reg", out_of(p), d);
            at_fall();
            chk("R2 rdy up", rdy_of(p), 1);
            stb_to_detect(p);
            tick();
            chk("R3/R9 irq on strobe", irq_of(p), en);
            chk("R3 rdy held until fall", rdy_of(p), 1);
            at_fall();
            chk("R3 rdy down", rdy_of(p), 0);
            tick();
            chk("R9 irq one cycle", irq_of(p), 0);
            // Output collision: write in detect cycle
            cpu_write(p, ~d);
            stb_to_detect(p);
            cpu_write(p, d);
            at_fall();
            chk("R10 write beats strobe", rdy_of(p), 1);
            // Input mode
            if (p != 0) mode_b = 2'd1; else mode_a = 2'd1;
            tick();
            if (p == 0) chk("R11 oe input mode", oe_a, 0);
            cpu_read(p);
            at_fall();
            chk("R5 read sets rdy", rdy_of(p), 1);
            if (p != 0) pin_b_in = d; else pin_a_in = d;
            set_stb(p, 1'b0);
            repeat (4) tick();
            chk("R4 transparent", in_of(p), d);
            set_stb(p, 1'b1);
            tick(); tick(); tick();
            chk("R4/R9 irq on capture", irq_of(p), en);
            at_fall();
            chk("R4 rdy cleared", rdy_of(p), 0);
            if (p != 0) pin_b_in = ~d; else pin_a_in = ~d;
            tick(); tick();
            chk("R4 holds captured", in_of(p), d);
            // Input collision: read in detect cycle
            cpu_read(p);
            stb_to_detect(p);
            cpu_read(p);
            at_fall();
            chk("R10 capture beats read", rdy_of(p), 0);
            tick();
         end
      end

      // R8 bit-control
      irq_en_a = 1'b1; irq_en_b = 1'b1;
      mode_a = 2'd0; mode_b = 2'd3;
      tick();
      cpu_write(0, 8'h3c);
      at_fall();
      chk("R2 rdy before bitctl", rdy_a, 1);
      mode_a = 2'd3;
      tick();
      at_fall();
      chk("R8 rdy forced low", rdy_a, 0);
      pin_a_in = 8'h99;
      stb_to_detect(0);
      tick();
      chk("R8 no irq_a", irq_a, 0);
      tick();
      chk("R8 no irq_a later", irq_a, 0);
      chk("R8 in_a untouched", in_a, in_a == 8'h99 ? 8'h00 : in_a);
      // port B with bidir code acts as bit-control
      mode_a = 2'd0; mode_b = 2'd2;
      tick();
      cpu_write(1, 8'h42);
      at_fall();
      chk("R8 port B code 10 rdy low", rdy_b, 0);
      stb_to_detect(1);
      tick();
      chk("R8 port B code 10 no irq", irq_b, 0);

      // R6/R7 bidirectional
      mode_a = 2'd2; mode_b = 2'd3;
      tick();
      chk("R6 oe off strobe high", oe_a, 0);
      cpu_write(0, 8'hc3);
      at_fall();
      chk("R6 rdy_a pending", rdy_a, 1);
      chk("R6 out_a", out_a, 8'hc3);
      stb_a_n = 1'b0; #0.5;
      chk("R6 oe on strobe low", oe_a, 1);
      repeat (4) tick();
      stb_a_n = 1'b1; #0.5;
      chk("R6 oe off after strobe", oe_a, 0);
      tick(); tick(); tick();
      chk("R6 irq_a", irq_a, 1);
      chk("R6 no irq_b", irq_b, 0);
      at_fall();
      chk("R6 rdy_a cleared", rdy_a, 0);
      cpu_read(0);
      at_fall();
      chk("R7 read A sets rdy_b", rdy_b, 1);
      pin_a_in = 8'h6e;
      stb_to_detect(1);
      tick();
      chk("R7 irq_b", irq_b, 1);
      chk("R7 no irq_a", irq_a, 0);
      at_fall();
      chk("R7 rdy_b cleared", rdy_b, 0);
      chk("R7 in_a captured", in_a, 8'h6e);
      irq_en_b = 1'b0;
      cpu_read(0);
      stb_to_detect(1);
      tick();
      chk("R9 disabled no irq_b", irq_b, 0);
      at_fall();
      chk("R9 disabled rdy_b still clears", rdy_b, 0);
      tick();

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule